// File: doc/BRIEF.md
# Nibble-Mode Reverse Byte Receiver

This block collects data flowing from a printer-style peripheral back to the host over a parallel port that has already been placed in nibble mode. The peripheral presents four data bits at a time on its status lines; the host side asks for each half with a request strobe and the peripheral answers with an acknowledge pulse. Two such exchanges, low half first, make one byte. The block delivers every completed byte on a valid/ready stream.

A transfer begins with a one-cycle start pulse carrying a byte count. The block then asks for nibbles, keeps track of two timeouts, and ends with a done pulse. The done pulse carries an error flag and a count of bytes the consumer has already taken. The status inputs are treated as asynchronous and go through a synchronizer before any decision is made. The two host lines that must stay high throughout are held high. All timeouts are counted in clock cycles.

Top module: `nib_rx`

## Requirements
- R1: While reset is held, and after it is released, the request output and both held-high outputs are 1, out_valid, done, err and xfer_busy are 0, and delivered is 0.
- R2: n_selectin and n_strobe are 1 at all times. A nibble request is signalled by driving n_autofd to 0.
- R3: Once the block sees st_nack low during a request, it raises n_autofd and latches the status lines. It issues no new request until st_nack has been seen high again.
- R4: Each received byte is built as follows. Bit 0 is st_nfault, bit 1 is st_select, bit 2 is st_perror and bit 3 is the level of st_busy, all taken from the first nibble. Bits 4, 5, 6 and 7 take the same four lines, in the same order, from the second nibble.
- R5: The peripheral may take up to IDLE_LIMIT cycles (default 2000) to answer the first nibble of a byte. The second nibble must be answered within RESP_LIMIT cycles (default 16).
- R6: After each nibble, st_nack must return high within RESP_LIMIT cycles. Any expired wait ends the transfer. In that case done and err pulse together, n_autofd is left at 1, and delivered holds the number of bytes the consumer took.
- R7: A byte is offered on out_data/out_valid only after both of its nibbles have completed their handshakes. out_data stays stable while out_valid is high and out_ready is low, and no request is made while a byte waits.
- R8: After byte_count bytes have been taken, done pulses for one cycle with err at 0. At that point delivered equals byte_count, xfer_busy is 0 and n_autofd is 1.
- R9: A start with a byte_count of 0 produces done without error and without any request.
- R10: A start pulse during a transfer is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transfer (ignored while busy) |
| byte_count | input | CNT_W | Number of bytes to receive, sampled with start |
| out_data | output | 8 | Assembled byte |
| out_valid | output | 1 | out_data holds a byte |
| out_ready | input | 1 | Consumer accepts the byte |
| xfer_busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| err | output | 1 | Pulses with done when a timeout ended the transfer |
| delivered | output | CNT_W | Bytes accepted in the current or last transfer |
| n_autofd | output | 1 | Nibble request, active low |
| n_selectin | output | 1 | Held high |
| n_strobe | output | 1 | Held high |
| st_nack | input | 1 | Peripheral acknowledge, low means nibble valid |
| st_busy | input | 1 | Status line, nibble bit 3 |
| st_perror | input | 1 | Status line, nibble bit 2 |
| st_select | input | 1 | Status line, nibble bit 1 |
| st_nfault | input | 1 | Status line, nibble bit 0 |

## Verification
The bench checks the two timeout windows against each other. A first nibble that arrives after several hundred cycles must succeed, while a second nibble that is only tens of cycles late must fail. A design that applied the long limit to both would accept the late one, and a design that applied the short limit to both would reject the slow one. The bench measures how long a silent peripheral holds the request low, which exposes a wrong window length. Random bytes exercise the pin-to-bit map, so a swapped or shifted nibble shows up as a miscompare. A stalled consumer checks that no request leaks out while a byte waits. The bench also sends a start pulse in the middle of a transfer and a start with zero bytes, so that a design which reloads its count or hangs shows up as an error or a wrong delivered count.

// File: rtl/nrx_pkg.sv
package nrx_pkg;
  localparam int NIB_W = 4;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_WLOW  = 2'd1,
    S_WHIGH = 2'd2,
    S_PUSH  = 2'd3
  } nrx_state_t;

  // Status lines to nibble: bit0 fault, bit1 select, bit2 paper error, bit3 busy level
  function automatic logic [NIB_W-1:0] status_nibble(input logic bsy, input logic pe,
                                                     input logic sel, input logic flt);
    return {bsy, pe, sel, flt};
  endfunction
endpackage

// File: rtl/nrx_sync.sv
module nrx_sync #(
  parameter int W = 5,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= RST_VAL;
        else     stage_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[s] <= RST_VAL;
        else     stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/nrx_timer.sv
module nrx_timer #(
  parameter int LONG_LIM  = 2000,
  parameter int SHORT_LIM = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic use_long,
  output logic expired
);
  localparam int TW = $clog2(LONG_LIM + 1);
  localparam logic [TW-1:0] LONG_V  = TW'(LONG_LIM);
  localparam logic [TW-1:0] SHORT_V = TW'(SHORT_LIM);

  logic [TW-1:0] cnt_q;

  assign expired = cnt_q >= (use_long ? LONG_V : SHORT_V);

  always_ff @(posedge clk) begin
    if (rst || clr)    cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nrx_ctrl.sv
module nrx_ctrl
  import nrx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  input  logic             ack_s,
  input  logic [NIB_W-1:0] nib_s,
  input  logic             out_ready,
  input  logic             tmr_exp,
  output logic             tmr_clr,
  output logic             tmr_long,
  output logic             n_autofd,
  output logic [7:0]       out_data,
  output logic             out_valid,
  output logic             xfer_busy,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] delivered
);
  nrx_state_t       state;
  logic             second;
  logic [NIB_W-1:0] lo_q, hi_q;
  logic [CNT_W-1:0] target;
  logic             advance;
  logic [CNT_W-1:0] deliv_nx;

  always_comb begin
    case (state)
      S_WLOW:  advance = !ack_s;
      S_WHIGH: advance = ack_s;
      default: advance = 1'b0;
    endcase
  end

  assign tmr_clr   = !(state == S_WLOW || state == S_WHIGH) || advance;
  assign tmr_long  = (state == S_WLOW) && !second;
  assign xfer_busy = (state != S_IDLE);
  assign deliv_nx  = delivered + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      second    <= 1'b0;
      lo_q      <= '0;
      hi_q      <= '0;
      target    <= '0;
      n_autofd  <= 1'b1;
      out_data  <= '0;
      out_valid <= 1'b0;
      done      <= 1'b0;
      err       <= 1'b0;
      delivered <= '0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: begin
          if (start) begin
            delivered <= '0;
            if (byte_count == '0) begin
              done <= 1'b1;
            end else begin
              target   <= byte_count;
              second   <= 1'b0;
              n_autofd <= 1'b0;
              state    <= S_WLOW;
            end
          end
        end
        S_WLOW: begin
          if (advance) begin
            if (second) hi_q <= nib_s;
            else        lo_q <= nib_s;
            n_autofd <= 1'b1;
            state    <= S_WHIGH;
          end else if (tmr_exp) begin
            n_autofd <= 1'b1;
            done     <= 1'b1;
            err      <= 1'b1;
            state    <= S_IDLE;
          end
        end
        S_WHIGH: begin
          if (advance) begin
            if (!second) begin
              second   <= 1'b1;
              n_autofd <= 1'b0;
              state    <= S_WLOW;
            end else begin
              out_data  <= {hi_q, lo_q};
              out_valid <= 1'b1;
              state     <= S_PUSH;
            end
          end else if (tmr_exp) begin
            done  <= 1'b1;
            err   <= 1'b1;
            state <= S_IDLE;
          end
        end
        S_PUSH: begin
          if (out_ready) begin
            out_valid <= 1'b0;
            delivered <= deliv_nx;
            if (deliv_nx == target) begin
              done  <= 1'b1;
              state <= S_IDLE;
            end else begin
              second   <= 1'b0;
              n_autofd <= 1'b0;
              state    <= S_WLOW;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_RAISE_AFTER_ACK: assert property (@(posedge clk) disable iff (rst)
    (state == S_WLOW && !ack_s) |=> n_autofd);                               // R3
  AST_VALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));         // R7
  AST_NO_REQ_WHILE_VALID: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> n_autofd);                                                 // R7
  AST_REQ_ONLY_IN_XFER: assert property (@(posedge clk) disable iff (rst)
    !n_autofd |-> (state == S_WLOW));                                        // R2
  AST_DELIV_BOUND: assert property (@(posedge clk) disable iff (rst)
    (state != S_IDLE) |-> (delivered < target));                             // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);                                                         // R8
  AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
    err |-> (done && n_autofd));                                             // R6
endmodule

// File: rtl/nib_rx.sv
module nib_rx
  import nrx_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int IDLE_LIMIT  = 2000,
  parameter int RESP_LIMIT  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] byte_count,
  output logic [7:0]       out_data,
  output logic             out_valid,
  input  logic             out_ready,
  output logic             xfer_busy,
  output logic             done,
  output logic             err,
  output logic [CNT_W-1:0] delivered,
  output logic             n_autofd,
  output logic             n_selectin,
  output logic             n_strobe,
  input  logic             st_nack,
  input  logic             st_busy,
  input  logic             st_perror,
  input  logic             st_select,
  input  logic             st_nfault
);
  localparam int SW = NIB_W + 1;

  logic [SW-1:0]    raw_lines, sync_lines;
  logic             tmr_clr, tmr_long, tmr_exp;

  assign raw_lines  = {st_nack, status_nibble(st_busy, st_perror, st_select, st_nfault)};
  assign n_selectin = 1'b1;
  assign n_strobe   = 1'b1;

  nrx_sync #(
    .W(SW), .STAGES(SYNC_STAGES), .RST_VAL({1'b1, {NIB_W{1'b0}}})
  ) u_sync (
    .clk(clk), .rst(rst), .d_in(raw_lines), .d_out(sync_lines)
  );

  nrx_timer #(
    .LONG_LIM(IDLE_LIMIT), .SHORT_LIM(RESP_LIMIT)
  ) u_timer (
    .clk(clk), .rst(rst), .clr(tmr_clr), .use_long(tmr_long), .expired(tmr_exp)
  );

  nrx_ctrl #(
    .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
    .ack_s(sync_lines[NIB_W]), .nib_s(sync_lines[NIB_W-1:0]),
    .out_ready(out_ready), .tmr_exp(tmr_exp),
    .tmr_clr(tmr_clr), .tmr_long(tmr_long),
    .n_autofd(n_autofd), .out_data(out_data), .out_valid(out_valid),
    .xfer_busy(xfer_busy), .done(done), .err(err), .delivered(delivered)
  );
endmodule

// File: tb/nib_rx_bench.sv
module nib_rx_bench;
  localparam int CNT_W = 8;
  localparam int IDLE_LIMIT = 2000;
  localparam int RESP_LIMIT = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [CNT_W-1:0] byte_count = '0;
  logic [7:0] out_data;
  logic out_valid;
  logic out_ready = 1'b0;
  logic xfer_busy, done, err;
  logic [CNT_W-1:0] delivered;
  logic n_autofd, n_selectin, n_strobe;
  logic st_nack = 1'b1, st_busy = 1'b0, st_perror = 1'b0, st_select = 1'b0, st_nfault = 1'b0;

  always #2 clk = ~clk;

  nib_rx #(.CNT_W(CNT_W), .IDLE_LIMIT(IDLE_LIMIT), .RESP_LIMIT(RESP_LIMIT)) u_nib_rx (
    .clk(clk), .rst(rst), .start(start), .byte_count(byte_count),
    .out_data(out_data), .out_valid(out_valid), .out_ready(out_ready),
    .xfer_busy(xfer_busy), .done(done), .err(err), .delivered(delivered),
    .n_autofd(n_autofd), .n_selectin(n_selectin), .n_strobe(n_strobe),
    .st_nack(st_nack), .st_busy(st_busy), .st_perror(st_perror),
    .st_select(st_select), .st_nfault(st_nfault)
  );

  int vectors = 0, fails = 0;
  int pin_viol = 0, req_viol = 0;
  int low_run = 0, low_max = 0;
  bit done_seen = 0, err_seen = 0;
  int ready_mode = 0, stall_left = 0;
  logic [7:0] rx_mem [256];
  int rx_n = 0;
  logic [7:0] tx_byte [256];
  int d_first [256], d_second [256], d_rel [256];
  bit inject_start = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Monitors and stream consumer
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin done_seen = 1; err_seen = err; end
      if (!(n_selectin && n_strobe)) pin_viol++;
      if (out_valid && !n_autofd) req_viol++;
      if (!n_autofd) begin low_run++; if (low_run > low_max) low_max = low_run; end
      else low_run = 0;
      if (ready_mode == 2 && out_valid && stall_left > 0) begin
        out_ready = 1'b0; stall_left--;
      end else if (ready_mode == 1) out_ready = 1'($urandom_range(0, 1));
      else out_ready = 1'b1;
      if (out_valid && out_ready) begin rx_mem[rx_n] = out_data; rx_n++; end
    end
  end

  // Peripheral: one nibble; dly < 0 means never answer
  task automatic periph_nibble(input logic [3:0] nib, input int dly, input int rel);
    while (n_autofd !== 1'b0 && xfer_busy) @(negedge clk);
    if (!xfer_busy) return;
    if (dly < 0) begin
      while (xfer_busy) @(negedge clk);
      return;
    end
    repeat (dly) @(negedge clk);
    st_nfault = nib[0]; st_select = nib[1]; st_perror = nib[2]; st_busy = nib[3];
    st_nack = 1'b0;
    @(negedge clk);
    while (n_autofd !== 1'b1) @(negedge clk);
    repeat (rel) @(negedge clk);
    st_nack = 1'b1;
    @(negedge clk);
  endtask

  task automatic periph_all(input int n);
    for (int i = 0; i < n; i++) begin
      periph_nibble(tx_byte[i][3:0], d_first[i], d_rel[i]);
      periph_nibble(tx_byte[i][7:4], d_second[i], d_rel[i]);
    end
  endtask

  task automatic run_xfer(input int n);
    done_seen = 0; err_seen = 0; rx_n = 0; low_max = 0;
    @(negedge clk); start = 1'b1; byte_count = CNT_W'(n);
    @(negedge clk); start = 1'b0;
    fork
      periph_all(n);
      begin
        while (!done_seen) @(negedge clk);
      end
      begin
        if (inject_start) begin
          repeat (5) @(negedge clk);
          start = 1'b1; byte_count = 8'd7;
          @(negedge clk); start = 1'b0;
        end
      end
    join
    repeat (2) @(negedge clk);
  endtask

  task automatic fill(input int n, input int dmax);
    for (int i = 0; i < n; i++) begin
      tx_byte[i]  = 8'($urandom_range(0, 255));
      d_first[i]  = $urandom_range(0, dmax);
      d_second[i] = $urandom_range(0, dmax);
      d_rel[i]    = $urandom_range(0, dmax);
    end
  endtask

  task automatic check_bytes(input string req, input int n);
    check(req, 32'(rx_n), 32'(n));
    for (int i = 0; i < n && i < rx_n; i++) check(req, 32'(rx_mem[i]), 32'(tx_byte[i]));
  endtask

  task automatic summary;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    void'($urandom(32'd1284));
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 autofd", 32'(n_autofd), 1);
    check("R1 valid/done/err/busy", {out_valid, done, err, xfer_busy}, 0);
    check("R1 delivered", 32'(delivered), 0);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 after release", {n_autofd, n_selectin, n_strobe, out_valid, xfer_busy}, 5'b11100);

    // R4 R8 directed byte with a known bit map
    tx_byte[0] = 8'hA5; d_first[0] = 1; d_second[0] = 1; d_rel[0] = 1;
    tx_byte[1] = 8'h3C; d_first[1] = 0; d_second[1] = 2; d_rel[1] = 0;
    run_xfer(2);
    check_bytes("R4 map", 2);
    check("R8 err", 32'(err_seen), 0);
    check("R8 done", 32'(done_seen), 1);
    check("R8 delivered", 32'(delivered), 2);
    check("R8 idle", {xfer_busy, n_autofd}, 2'b01);

    // R3 R4 R8 random transfers with random consumer
    ready_mode = 1;
    for (int t = 0; t < 6; t++) begin
      int n = $urandom_range(1, 10);
      fill(n, 5);
      run_xfer(n);
      check_bytes("R4 random", n);
      check("R8 delivered random", 32'(delivered), 32'(n));
      check("R8 no err random", 32'(err_seen), 0);
    end

    // R7 stalled consumer
    ready_mode = 2; stall_left = 60;
    fill(3, 3);
    run_xfer(3);
    check_bytes("R7 stall", 3);
    check("R7 no request while valid", 32'(req_viol), 0);
    ready_mode = 0;

    // R9 zero count
    run_xfer(0);
    check("R9 done", {done_seen, err_seen}, 2'b10);
    check("R9 no request", 32'(low_max), 0);

    // R10 start ignored while busy
    inject_start = 1;
    fill(2, 4);
    run_xfer(2);
    inject_start = 0;
    check("R10 delivered", 32'(delivered), 2);
    check("R10 no err", 32'(err_seen), 0);

    // R5 slow first nibble is accepted
    fill(1, 2); d_first[0] = 300;
    run_xfer(1);
    check_bytes("R5 slow first", 1);
    check("R5 slow first no err", 32'(err_seen), 0);

    // R5 R6 late second nibble times out on the short window
    fill(3, 2); d_second[1] = 40;
    run_xfer(3);
    check("R5 late second err", 32'(err_seen), 1);
    check("R6 delivered on err", 32'(delivered), 1);
    check("R5 short window", 32'(low_max >= RESP_LIMIT && low_max <= RESP_LIMIT + 4), 1);
    check("R6 autofd high", 32'(n_autofd), 1);

    // R6 late release
    fill(2, 2); d_rel[0] = 40;
    run_xfer(2);
    check("R6 release err", 32'(err_seen), 1);
    check("R6 release delivered", 32'(delivered), 0);

    // R5 silent peripheral on first nibble
    fill(2, 2); d_first[1] = -1;
    run_xfer(2);
    check("R5 silent err", 32'(err_seen), 1);
    check("R5 silent delivered", 32'(delivered), 1);
    check("R5 long window", 32'(low_max >= IDLE_LIMIT && low_max <= IDLE_LIMIT + 4), 1);

    // R2 held-high lines over the whole run
    check("R2 select/strobe high", 32'(pin_viol), 0);
    check("R7 request during valid", 32'(req_viol), 0);
    summary();
  end
endmodule